// File: doc/BRIEF.md
# Flash Status Register Protection Guard

This block keeps the protection and control bits of a serial flash status word and decides, request by request, whether a Write Status operation may change them. A two-bit protection mode held in the word, together with the write-protect pin, selects one of four policies. In open mode any write succeeds once the write-enable latch is set. In pin-gated mode a low pin blocks writes. In held mode every write is refused until the next power cycle. In sealed mode every write is refused for good.

The instruction decoder supplies an opcode strobe, a write-status request with its 16-bit data word and the write-enable latch state. A separate power-cycle event models a supply drop and restore, and it is distinct from the ordinary reset. The block returns the status word, one-cycle accept and reject pulses, a pulse that asks the write-enable logic to clear the latch, and a flag that turns the protect/hold pins into quad data pins. The ordinary reset loads the blank-part state, which is all zeros. Nonvolatile bits survive a power-cycle event.

Top module: `sreg_guard`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `status`=0, `quad_mode`=0 and `wr_acc`=`wr_rej`=`wel_clr`=0.
- R2: With mode bits {status[8],status[7]}=00, a request sampled with `wel`=1 is accepted whatever the level of `wp_n`. After that edge, status[14:2] equal wrsr_data[14:2], and `wr_acc` and `wel_clr` are high for exactly one cycle.
- R3: A request sampled with `wel`=0 raises `wr_rej` for one cycle and leaves status[14:0] unchanged.
- R4: In mode 01 with status[9]=0, a request is rejected while the synchronized pin is low and accepted (given `wel`=1) while it is high. A change on `wp_n` reaches the decision through two flip-flops, so a request sampled at the first edge after the change still sees the old level.
- R5: In mode 01 with status[9]=1, the pin takes no part in the decision, and requests with `wel`=1 are accepted.
- R6: In mode 10 every request is rejected. A power-cycle event returns the mode bits to 00 and keeps status[14:9] and status[6:2].
- R7: In mode 11 every request is rejected, and status[14:0] is kept across power-cycle events.
- R8: status[15] (suspend) is read-only to writes. An opcode strobe with 8'h75 sets it and one with 8'h7A clears it, and the opcode acts in the same cycle as an accepted write.
- R9: A power-cycle event clears status[15], keeps every other bit (except for the R6 mode rule), and drops any request or opcode sampled in the same cycle with no result pulse.
- R10: `quad_mode` equals status[9].
- R11: status[1:0] always read 0, whatever the write data.
- R12: `wr_acc` and `wr_rej` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to blank state |
| pwr_cycle | input | 1 | One-cycle power-down/power-up event |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 8 | Decoded opcode |
| wrsr_req | input | 1 | Write Status request |
| wrsr_data | input | 16 | Write Status data word |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Active-low write-protect pin, asynchronous |
| status | output | 16 | Current status word |
| wr_acc | output | 1 | Request accepted pulse |
| wr_rej | output | 1 | Request rejected pulse |
| wel_clr | output | 1 | Pulse asking the write-enable latch to clear |
| quad_mode | output | 1 | 1: protect/hold pins act as quad IO2/IO3 |

## Verification
Two pairs of functions can meet in one cycle. A suspend or resume opcode can arrive together with an accepted write whose data tries to set bit 15. A power-cycle event can also arrive together with a pending request. The bench drives both pairs in the same clock. It expects the opcode alone to decide bit 15 while the other written bits update. It expects the power cycle to win, with no result pulse and the mode 10 release applied.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
  localparam int SR_W   = 16;
  localparam int OP_W   = 8;
  localparam int SUS_B  = 15;
  localparam int QE_B   = 9;
  localparam int MODE_HI = 8;
  localparam int MODE_LO = 7;
  localparam logic [OP_W-1:0] OP_SUSPEND = 8'h75;
  localparam logic [OP_W-1:0] OP_RESUME  = 8'h7A;
  // bits a Write Status request may change
  localparam logic [SR_W-1:0] WR_MASK = 16'h7FFC;

  typedef enum logic [1:0] {
    PM_OPEN = 2'b00,
    PM_PIN  = 2'b01,
    PM_HELD = 2'b10,
    PM_SEAL = 2'b11
  } prot_mode_e;
endpackage

// File: rtl/sreg_wp_sync.sv
module sreg_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= pin_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/sreg_lock_eval.sv
module sreg_lock_eval
  import sreg_guard_pkg::*;
(
  input  prot_mode_e mode,
  input  logic       quad_en,
  input  logic       wp_level,
  input  logic       wel,
  output logic       accept
);
  always_comb begin
    case (mode)
      PM_OPEN: accept = wel;
      // with quad enabled the pin carries data, so it cannot gate
      PM_PIN:  accept = wel && (quad_en || wp_level);
      default: accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/sreg_store.sv
module sreg_store
  import sreg_guard_pkg::*;
#(
  parameter int W   = SR_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_cycle,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic           wrsr_req,
  input  logic [W-1:0]   wrsr_data,
  input  logic           accept,
  output logic [W-1:0]   sr,
  output logic           acc_p,
  output logic           rej_p,
  output logic           clr_p
);
  localparam logic [W-1:0] MASK = W'(WR_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      acc_p <= 1'b0;
      rej_p <= 1'b0;
      clr_p <= 1'b0;
    end else begin
      acc_p <= 1'b0;
      rej_p <= 1'b0;
      clr_p <= 1'b0;
      if (pwr_cycle) begin
        sr[SUS_B] <= 1'b0;
        if (sr[MODE_HI:MODE_LO] == PM_HELD)
          sr[MODE_HI:MODE_LO] <= PM_OPEN;
      end else begin
        if (wrsr_req) begin
          if (accept) begin
            sr    <= (sr & ~MASK) | (wrsr_data & MASK);
            acc_p <= 1'b1;
            clr_p <= 1'b1;
          end else begin
            rej_p <= 1'b1;
          end
        end
        if (op_valid && op_code == OP_SUSPEND)
          sr[SUS_B] <= 1'b1;
        else if (op_valid && op_code == OP_RESUME)
          sr[SUS_B] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_cycle,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic            wrsr_req,
  input  logic [SR_W-1:0] wrsr_data,
  input  logic            wel,
  input  logic            wp_n,
  output logic [SR_W-1:0] status,
  output logic            wr_acc,
  output logic            wr_rej,
  output logic            wel_clr,
  output logic            quad_mode
);
  logic       wp_s;
  logic       accept;
  prot_mode_e mode;

  sreg_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(wp_n), .pin_sync(wp_s)
  );

  assign mode = prot_mode_e'(status[MODE_HI:MODE_LO]);

  sreg_lock_eval u_eval (
    .mode(mode), .quad_en(status[QE_B]), .wp_level(wp_s),
    .wel(wel), .accept(accept)
  );

  sreg_store #(.W(SR_W), .OPW(OP_W)) u_store (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle),
    .op_valid(op_valid), .op_code(op_code),
    .wrsr_req(wrsr_req), .wrsr_data(wrsr_data), .accept(accept),
    .sr(status), .acc_p(wr_acc), .rej_p(wr_rej), .clr_p(wel_clr)
  );

  assign quad_mode = status[QE_B];
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        pwr_cycle,
  input logic        op_valid,
  input logic [7:0]  op_code,
  input logic        wrsr_req,
  input logic        wr_acc,
  input logic        wr_rej,
  input logic [15:0] status
);
  p_excl_result_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_acc, wr_rej}));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_rej && !$past(rst)) |-> status[14:0] == $past(status[14:0]));

  p_sealed_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status[8:7]) == 2'b11) |->
      status[14:0] == $past(status[14:0]));

  p_suspend_sets_r8: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && op_code == 8'h75 && !pwr_cycle && !rst) |-> status[15]);

  p_pwr_drop_r9: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_cycle && !rst) |-> (!status[15] && !wr_acc && !wr_rej));

  p_low_bits_r11: assert property (@(posedge clk) disable iff (rst)
    status[1:0] == 2'b00);
endmodule

bind sreg_guard sreg_guard_chk u_chk (
  .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .op_valid(op_valid),
  .op_code(op_code), .wrsr_req(wrsr_req), .wr_acc(wr_acc),
  .wr_rej(wr_rej), .status(status)
);

// File: tb/sreg_guard_test.sv
module sreg_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_cycle = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic        wrsr_req = 1'b0;
  logic [15:0] wrsr_data = 16'h0000;
  logic        wel = 1'b0;
  logic        wp_n = 1'b0;
  logic [15:0] status;
  logic        wr_acc, wr_rej, wel_clr, quad_mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sreg_guard uut (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .op_valid(op_valid),
    .op_code(op_code), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
    .wel(wel), .wp_n(wp_n), .status(status), .wr_acc(wr_acc),
    .wr_rej(wr_rej), .wel_clr(wel_clr), .quad_mode(quad_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request sampled at the next edge; results sampled at the negedge after
  task automatic request(input logic [15:0] d, input logic en, input logic sus,
                         input logic res, input logic pc);
    wrsr_data = d;
    wel       = en;
    wrsr_req  = 1'b1;
    op_valid  = sus | res;
    op_code   = sus ? 8'h75 : (res ? 8'h7A : 8'h00);
    pwr_cycle = pc;
    @(negedge clk);
    wrsr_req  = 1'b0;
    op_valid  = 1'b0;
    pwr_cycle = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [15:0] st,
                               input logic a, input logic r);
    check(req, {16'h0, status}, {16'h0, st});
    check(req, {29'h0, wr_acc, wr_rej, wel_clr}, {29'h0, a, r, a});
    @(negedge clk);
    check("R12", {30'h0, wr_acc, wr_rej}, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", {16'h0, status}, 32'h0);
    check("R1", {30'h0, quad_mode, wr_acc | wr_rej | wel_clr}, 32'h0);
  endtask

  task automatic t_open();
    // pin low, open mode: accepted, bit15 and bits 1:0 of data dropped
    request(16'hFC7F, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R2_R11", 16'h7C7C, 1'b1, 1'b0);
  endtask

  task automatic t_no_wel();
    request(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_result("R3", 16'h7C7C, 1'b0, 1'b1);
  endtask

  task automatic t_quad_flag();
    request(16'h0200, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", {31'h0, quad_mode}, 32'h1);
    expect_result("R10", 16'h0200, 1'b1, 1'b0);
    request(16'h0080, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", {31'h0, quad_mode}, 32'h0);
    expect_result("R2", 16'h0080, 1'b1, 1'b0);
  endtask

  task automatic t_pin_gate();
    request(16'h0004, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R4", 16'h0080, 1'b0, 1'b1);
    wp_n = 1'b1;
    request(16'h0004, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R4_latency", 16'h0080, 1'b0, 1'b1);
    request(16'h0084, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R4", 16'h0084, 1'b1, 1'b0);
  endtask

  task automatic t_quad_bypass();
    request(16'h0280, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R5", 16'h0280, 1'b1, 1'b0);
    wp_n = 1'b0;
    idle(3);
    request(16'h0288, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R5", 16'h0288, 1'b1, 1'b0);
    request(16'h0080, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R5", 16'h0080, 1'b1, 1'b0);
    request(16'h0090, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R4", 16'h0080, 1'b0, 1'b1);
    wp_n = 1'b1;
    idle(3);
  endtask

  task automatic t_suspend();
    request(16'h8084, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_result("R8_same_cycle", 16'h8084, 1'b1, 1'b0);
    request(16'h8080, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_result("R8_resume", 16'h0080, 1'b1, 1'b0);
    op_valid = 1'b1; op_code = 8'h75;
    @(negedge clk);
    op_valid = 1'b0;
    check("R8", {16'h0, status}, 32'h8080);
    pwr_cycle = 1'b1;
    @(negedge clk);
    pwr_cycle = 1'b0;
    check("R9", {16'h0, status}, 32'h0080);
  endtask

  task automatic t_held();
    request(16'h0140, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R6", 16'h0140, 1'b1, 1'b0);
    request(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R6", 16'h0140, 1'b0, 1'b1);
    // power cycle together with a request: request dropped, mode released
    request(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_result("R6_R9", 16'h0040, 1'b0, 1'b0);
    request(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R6", 16'h0000, 1'b1, 1'b0);
  endtask

  task automatic t_sealed();
    request(16'h0184, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R7", 16'h0184, 1'b1, 1'b0);
    request(16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_result("R7", 16'h0184, 1'b0, 1'b1);
    pwr_cycle = 1'b1;
    @(negedge clk);
    pwr_cycle = 1'b0;
    check("R7", {16'h0, status}, 32'h0184);
    request(16'h0004, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_result("R7_R8", 16'h8184, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_open();
    t_no_wel();
    t_quad_flag();
    t_pin_gate();
    t_quad_bypass();
    t_suspend();
    t_held();
    t_sealed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule